// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind the serial protocol front end of a page-organised nonvolatile memory. The front end hands it four things: a pulse when a bus transaction opens, a start address, the data bytes of a write transaction one at a time, and a pulse when the transaction closes. The block keeps one page of bytes, with a valid flag for each byte. It commits that page to the array only when the transaction closes.

A commit scans every slot of the page once, in ascending slot order. It drives one array write for each valid slot and skips the others. After the scan it holds `busy` for a programmable number of cycles that stands in for the cell write time. While `busy` is high the block ignores all of its inputs.

The block also keeps the internal address pointer. This pointer is the address that a following read without an address phase uses. The block updates it after a write according to fixed rules. It also loads it directly when an address phase ends without data, which is the case of a dummy write that comes before a random read. A write-protect level is sampled when the transaction opens and again when it closes. If it is high at either sample, the array is left untouched.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` is 0, `arrWe` is 0 and `ptrOut` is 0.
- R2: An `addrLoad` pulse while idle sets `ptrOut` to `addrIn` on the next cycle. A transaction that closes with no data byte leaves it there.
- R3: Each accepted data byte goes to the slot given by the low log2(PAGE_BYTES) address bits. That slot index starts at the low bits of the loaded address and advances by one per byte. Every array write of a commit carries the upper address bits of the loaded address.
- R4: The slot index wraps from PAGE_BYTES-1 to 0. When more than one byte lands in the same slot, the byte sent last is the one written.
- R5: `stopSeen` with no accepted byte since the last `addrLoad` starts no array write and leaves `busy` low.
- R6: A commit writes each valid slot exactly once, one slot per cycle, in ascending slot order. It writes no other slot. `arrWe` is high only while `busy` is high.
- R7: An unprotected commit holds `busy` high for exactly PAGE_BYTES + WRITE_CYCLES cycles. `busy` rises on the cycle after `stopSeen`.
- R8: If `wpIn` is high at the `startSeen` pulse, or at the `stopSeen` pulse, the commit makes no array write and `busy` stays low. The pointer is still updated as in R9.
- R9: After a transaction with n bytes, where 1 <= n < PAGE_BYTES, `ptrOut` keeps the upper bits of the start address and has low bits (start low bits + n) mod PAGE_BYTES. If n >= PAGE_BYTES, `ptrOut` equals the start address. In particular, one byte written to low bits 111111 leaves low bits 000000.
- R10: While `busy` is high, `addrLoad`, `byteValid`, `stopSeen` and `startSeen` have no effect. The pointer, the written data and the busy length are unchanged.
- R11: A data byte that arrives with no `addrLoad` since the last close of a transaction is dropped. A following `stopSeen` then commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startSeen | input | 1 | One-cycle pulse: a bus transaction opened |
| wpIn | input | 1 | Write-protect level |
| addrLoad | input | 1 | One-cycle pulse: `addrIn` holds the transaction start address |
| addrIn | input | ADDR_W | Start address |
| byteValid | input | 1 | One-cycle pulse: `byteIn` holds a data byte |
| byteIn | input | 8 | Data byte |
| stopSeen | input | 1 | One-cycle pulse: the transaction closed |
| busy | output | 1 | Commit in progress; inputs are ignored |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | 8 | Array write data |
| ptrOut | output | ADDR_W | Internal address pointer |

## Verification
The bench aims at page rollover and same-slot overwrite. It sends ten bytes that cross the end of the page, and seventy bytes that lap it. A design that carried into the upper address bits would write to the wrong page, and one that kept the first byte of a slot would write stale data; the scoreboard catches both on the array port. The pointer cases cover a single byte at the last slot, exactly one page of bytes, and more than a page. A pointer adder without an in-page wrap, or a missing rule for the full page, gives a wrong `ptrOut`. The bench drives write-protect high only at the open, and then only at the close, so a design that samples it just once writes the array. It also sends pulses during `busy` and a byte with no address phase; a design that accepts them moves the pointer or starts an extra commit.

// File: rtl/page_write_seq_pkg.sv
package page_write_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic commitPtr;
    logic clearBuf;
    logic scanStep;
  } pwStrobe_t;

endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import page_write_seq_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        byteIn,
  output logic              hasData,
  output logic              scanLast,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic [ADDR_W-1:0] ptrOut
);

  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = SLOT_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] startAddr;
  logic [SLOT_W-1:0] cursor;
  logic [CNT_W-1:0]  byteCount;
  logic              armed;
  logic [SLOT_W-1:0] scanIdx;
  logic [ADDR_W-1:0] ptrQ;
  logic [PAGE_BYTES-1:0] slotValid;
  logic [7:0]        slotData [PAGE_BYTES];
  logic              acceptByte;
  logic [SLOT_W-1:0] lowSum;
  logic [ADDR_W-1:0] ptrAfter;

  assign acceptByte = strb.storeByte && armed;

  // per-slot storage: valid flag and byte, later bytes overwrite earlier ones
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotData[g]  <= 8'h00;
      end else if (strb.clearBuf || strb.loadAddr) begin
        slotValid[g] <= 1'b0;
      end else if (acceptByte && (cursor == SLOT_W'(g))) begin
        slotValid[g] <= 1'b1;
        slotData[g]  <= byteIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      cursor    <= '0;
      byteCount <= '0;
      armed     <= 1'b0;
    end else if (strb.loadAddr) begin
      startAddr <= addrIn;
      cursor    <= addrIn[SLOT_W-1:0];
      byteCount <= '0;
      armed     <= 1'b1;
    end else if (strb.clearBuf) begin
      byteCount <= '0;
      armed     <= 1'b0;
    end else if (acceptByte) begin
      cursor <= cursor + 1'b1;
      if (byteCount != FULL_CNT) byteCount <= byteCount + 1'b1;
    end
  end

  // pointer left behind after a write
  assign lowSum   = startAddr[SLOT_W-1:0] + byteCount[SLOT_W-1:0];
  assign ptrAfter = (byteCount == FULL_CNT) ? startAddr
                  : {startAddr[ADDR_W-1:SLOT_W], lowSum};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptrQ <= '0;
    else if (strb.loadAddr)  ptrQ <= addrIn;
    else if (strb.commitPtr) ptrQ <= ptrAfter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              scanIdx <= '0;
    else if (strb.scanStep) scanIdx <= scanIdx + 1'b1;
  end

  assign hasData  = (byteCount != '0);
  assign scanLast = (scanIdx == SLOT_W'(PAGE_BYTES - 1));
  assign arrWe    = strb.scanStep && slotValid[scanIdx];
  assign arrAddr  = {startAddr[ADDR_W-1:SLOT_W], scanIdx};
  assign arrData  = slotData[scanIdx];
  assign ptrOut   = ptrQ;

endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import page_write_seq_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startSeen,
  input  logic      wpIn,
  input  logic      addrLoad,
  input  logic      byteValid,
  input  logic      stopSeen,
  input  logic      hasData,
  input  logic      scanLast,
  output pwStrobe_t strb,
  output logic      busy
);

  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);

  seqState_t  state, stateNext;
  logic [TMR_W-1:0] timer;
  logic       wpAtOpen;
  logic       idle;
  logic       stopNow;
  logic       protect;
  logic       goScan;

  assign idle    = (state == ST_IDLE);
  assign stopNow = idle && stopSeen;
  assign protect = wpAtOpen || wpIn;
  assign goScan  = stopNow && hasData && !protect;

  always_comb begin
    strb           = '0;
    strb.loadAddr  = idle && addrLoad;
    strb.storeByte = idle && byteValid && !addrLoad;
    strb.commitPtr = stopNow && hasData;
    strb.scanStep  = (state == ST_SCAN);
    strb.clearBuf  = (stopNow && !goScan) || ((state == ST_SCAN) && scanLast);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (goScan) stateNext = ST_SCAN;
      ST_SCAN: if (scanLast) stateNext = ST_HOLD;
      ST_HOLD: if (timer == TMR_LAST) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (state != ST_HOLD) timer <= '0;
    else                       timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wpAtOpen <= 1'b0;
    else if (idle && startSeen) wpAtOpen <= wpIn;
  end

  assign busy = !idle;

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import page_write_seq_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              wpIn,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic              stopSeen,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic [ADDR_W-1:0] ptrOut
);

  pwStrobe_t strb;
  logic      hasData;
  logic      scanLast;

  pwb_control #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .wpIn(wpIn),
    .addrLoad(addrLoad), .byteValid(byteValid), .stopSeen(stopSeen),
    .hasData(hasData), .scanLast(scanLast), .strb(strb), .busy(busy)
  );

  pwb_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .byteIn(byteIn),
    .hasData(hasData), .scanLast(scanLast), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData), .ptrOut(ptrOut)
  );

endmodule

// File: rtl/page_write_seq_checker.sv
module page_write_seq_checker #(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 200
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpIn,
  input logic              stopSeen,
  input logic              busy,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic [ADDR_W-1:0] ptrOut
);

  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int LEN_W  = $clog2(PAGE_BYTES + WRITE_CYCLES + 2) + 1;
  localparam logic [LEN_W-1:0] BUSY_LEN = LEN_W'(PAGE_BYTES + WRITE_CYCLES);

  logic [LEN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_we_inside_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !busy && wpIn) |=> !busy);

  assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ptrOut));

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |->
      (arrAddr[ADDR_W-1:SLOT_W] == $past(arrAddr[ADDR_W-1:SLOT_W])));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == BUSY_LEN));

endmodule

bind page_write_seq page_write_seq_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .wpIn(wpIn), .stopSeen(stopSeen), .busy(busy),
  .arrWe(arrWe), .arrAddr(arrAddr), .ptrOut(ptrOut)
);

// File: tb/page_write_seq_tb_top.sv
module page_write_seq_tb_top;

  localparam int AW   = 14;
  localparam int PAGE = 64;
  localparam int WC   = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startSeen = 1'b0, wpIn = 1'b0, addrLoad = 1'b0;
  logic          byteValid = 1'b0, stopSeen = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    byteIn = '0;
  logic          busy, arrWe;
  logic [AW-1:0] arrAddr, ptrOut;
  logic [7:0]    arrData;

  int checks = 0;
  int bad = 0;
  int busyRun = 0;
  int lastBusyLen = 0;
  bit finished = 1'b0;
  logic [AW-1:0] expAddrQ[$];
  logic [7:0]    expDataQ[$];

  always #10 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .wpIn(wpIn),
    .addrLoad(addrLoad), .addrIn(addrIn), .byteValid(byteValid),
    .byteIn(byteIn), .stopSeen(stopSeen), .busy(busy), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData), .ptrOut(ptrOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard of array writes and busy run length
  always @(negedge clk) begin
    if (rstN) begin
      if (arrWe) begin
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R6 unexpected array write", int'(arrAddr), -1);
        end else begin
          logic [AW-1:0] ea;
          logic [7:0]    ed;
          ea = expAddrQ.pop_front();
          ed = expDataQ.pop_front();
          check(arrAddr == ea, "R3/R6 write address", int'(arrAddr), int'(ea));
          check(arrData == ed, "R4/R6 write data", int'(arrData), int'(ed));
        end
      end
      if (busy) busyRun++;
      else if (busyRun > 0) begin
        lastBusyLen = busyRun;
        busyRun = 0;
      end
    end
  end

  task automatic pulseStart();
    @(posedge clk); #1 startSeen = 1'b1;
    @(posedge clk); #1 startSeen = 1'b0;
  endtask

  task automatic pulseAddr(input logic [AW-1:0] a);
    @(posedge clk); #1 addrLoad = 1'b1; addrIn = a;
    @(posedge clk); #1 addrLoad = 1'b0;
  endtask

  task automatic pulseByte(input logic [7:0] b);
    @(posedge clk); #1 byteValid = 1'b1; byteIn = b;
    @(posedge clk); #1 byteValid = 1'b0;
  endtask

  task automatic pulseStop();
    @(posedge clk); #1 stopSeen = 1'b1;
    @(posedge clk); #1 stopSeen = 1'b0;
  endtask

  // driver: one write transaction with its expected results
  task automatic writeTxn(input logic [AW-1:0] startA, input int n, input int seed,
                          input bit wpOpen, input bit wpClose, input bit inject);
    bit            mVal [PAGE];
    logic [7:0]    mDat [PAGE];
    bit            commit;
    logic [AW-1:0] expPtr;
    commit = (n > 0) && !wpOpen && !wpClose;
    for (int s = 0; s < PAGE; s++) mVal[s] = 1'b0;
    for (int i = 0; i < n; i++) begin
      int s;
      s = (int'(startA) + i) % PAGE;
      mVal[s] = 1'b1;
      mDat[s] = 8'((seed + i * 7) & 8'hFF);
    end
    if (commit) begin
      for (int s = 0; s < PAGE; s++) begin
        if (mVal[s]) begin
          expAddrQ.push_back({startA[AW-1:6], 6'(s)});
          expDataQ.push_back(mDat[s]);
        end
      end
    end
    if (n == 0 || n >= PAGE) expPtr = startA;
    else expPtr = {startA[AW-1:6], 6'((int'(startA[5:0]) + n) % PAGE)};

    wpIn = wpOpen;
    pulseStart();
    wpIn = 1'b0;
    pulseAddr(startA);
    for (int i = 0; i < n; i++) pulseByte(8'((seed + i * 7) & 8'hFF));
    wpIn = wpClose;
    pulseStop();
    wpIn = 1'b0;
    if (commit) begin
      if (inject) begin
        // R10: all of these land while busy is high
        pulseStart();
        pulseAddr(14'h3ABC);
        pulseByte(8'hEE);
        pulseStop();
      end
      @(negedge clk);
      while (busy) @(negedge clk);
      #1;
      check(lastBusyLen == PAGE + WC, "R7 busy length", lastBusyLen, PAGE + WC);
      check(expAddrQ.size() == 0, "R6 writes outstanding", expAddrQ.size(), 0);
    end else begin
      @(negedge clk);
      check(busy == 1'b0, (n == 0) ? "R5 busy after empty close" : "R8 busy when protected",
            int'(busy), 0);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R5/R8 busy stays low", int'(busy), 0);
    end
    check(ptrOut == expPtr, inject ? "R10/R9 pointer" : "R9/R2 pointer",
          int'(ptrOut), int'(expPtr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(arrWe == 1'b0, "R1 arrWe in reset", int'(arrWe), 0);
    check(ptrOut == '0, "R1 ptr in reset", int'(ptrOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && ptrOut == '0, "R1 after release", int'(ptrOut), 0);

    // R11: byte without address phase is dropped
    pulseByte(8'h5A);
    pulseStop();
    @(negedge clk);
    check(busy == 1'b0, "R11 no commit", int'(busy), 0);
    check(ptrOut == '0, "R11 ptr unchanged", int'(ptrOut), 0);

    // R2: address load moves the pointer at once
    pulseAddr(14'h1234);
    @(negedge clk);
    check(ptrOut == 14'h1234, "R2 pointer load", int'(ptrOut), 'h1234);
    pulseStop();

    writeTxn(14'h0105, 1,  8'h11, 1'b0, 1'b0, 1'b0);   // R3 byte write
    writeTxn(14'h02FF, 1,  8'h22, 1'b0, 1'b0, 1'b0);   // R9 last slot -> low 000000
    writeTxn(14'h0438, 10, 8'h33, 1'b0, 1'b0, 1'b0);   // R4 wrap inside page
    writeTxn(14'h0810, 70, 8'h44, 1'b0, 1'b0, 1'b0);   // R4 lap, last wins; R9 ptr=start
    writeTxn(14'h0C00, 64, 8'h55, 1'b0, 1'b0, 1'b0);   // R9 exactly one page
    writeTxn(14'h1000, 5,  8'h66, 1'b1, 1'b0, 1'b0);   // R8 protect at open
    writeTxn(14'h1100, 5,  8'h77, 1'b0, 1'b1, 1'b0);   // R8 protect at close
    writeTxn(14'h2222, 0,  8'h00, 1'b0, 1'b0, 1'b0);   // R5 dummy write, R2 ptr
    writeTxn(14'h1F3C, 3,  8'h88, 1'b0, 1'b0, 1'b1);   // R10 pulses while busy

    // R11 again after a completed commit
    pulseByte(8'hC3);
    pulseStop();
    @(negedge clk);
    check(busy == 1'b0, "R11 no commit after close", int'(busy), 0);

    repeat (5) @(negedge clk);
    check(expAddrQ.size() == 0, "R6 queue empty at end", expAddrQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule